// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Sequencer

This block drives the three-wire serial bus of a dual-loop frequency synthesizer. The bus has a serial clock, a data line and a load-enable line. A one-cycle start strobe begins a transaction. What the transaction sends depends on the mode input, which is sampled when the strobe is accepted.

In burst mode the sequencer sends four programming words in a fixed order. A separate step output pulses together with the load-enable pulse of the third word only. That word is the main divider of the first loop, so the pulse gives an instrument a trigger for timing how long the loop takes to lock.

In toggle mode the sequencer sends only that main-divider word. It alternates between a base value and an offset value, and it waits a programmable number of clock cycles between events. The step output fires on every event. Toggle mode keeps running while the mode input stays high. The word being sent always completes before the sequencer stops. Working out word contents from frequencies is done elsewhere.

Top module: `synth_prog_seq`

## Requirements
- R1: After reset, `sclk`, `sdata`, `le`, `step` and `busy` are all low.
- R2: Each word is 23 bits long and is sent MSB first. Each bit lasts one bit period of 2*HALF clock cycles, with `sclk` low in the first HALF cycles and high in the second HALF cycles. `sdata` changes only while `sclk` is low, and the receiver samples it on the rising edge of `sclk`.
- R3: `le` stays low while bits are shifted. It goes high for exactly one bit period after the last bit of each word, and `sclk` is low for the whole of that pulse.
- R4: In burst mode (`toggle_mode` low when start is accepted), each transaction sends four words from `prog_words`. Word k is taken from bits [k*23 +: 23], and they are sent in the order k = 0, 1, 2, 3. `busy` stays high for exactly 4*(2*HALF*25+1) cycles.
- R5: In burst mode, `step` goes high only during the `le` pulse of word k = 2, and it matches that pulse cycle for cycle. `step` is never high while `le` is low.
- R6: In toggle mode, only the main-divider word is sent. The first event sends `tog_base`, the next sends `tog_alt`, and they keep alternating. `step` goes high with every `le` pulse.
- R7: The spacing from one rising edge of `le` to the next is 2*HALF*25+1 cycles within a burst. In toggle mode it is 2*HALF*25+`tog_delay`+2 cycles. This leaves at least one idle bit period between consecutive words.
- R8: A start strobe that arrives while `busy` is high is ignored. It does not restart the transaction or lengthen it, and it adds no words.
- R9: When `toggle_mode` is cleared during a word, that word completes and then `busy` falls with no further word. When it is cleared during the inter-event delay, `busy` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transaction |
| toggle_mode | input | 1 | 1 selects toggle mode; clearing it stops toggling |
| prog_words | input | 92 | Four burst words, word k at bits [k*23 +: 23] |
| tog_base | input | 23 | Base value of the toggled main-divider word |
| tog_alt | input | 23 | Offset value of the toggled main-divider word |
| tog_delay | input | 12 | Extra cycles between toggle events |
| sclk | output | 1 | Serial bus clock |
| sdata | output | 1 | Serial bus data, MSB first |
| le | output | 1 | Load enable, one bit period per word |
| step | output | 1 | Lock-time trigger, coincident with the main-divider load |
| busy | output | 1 | Transaction in progress |

## Verification
A wrong word index or a wrong toggle-select state appears at the very next load-enable pulse. The captured word differs, or `step` fires on the wrong pulse. A bit-counter or bit-timer fault changes the number of `sclk` rising edges before `le`, or the width of `le`, within one word time. Faults in the sequencer state show up as a wrong spacing between `le` edges or a wrong `busy` length. Both are measured in exact cycles on every transaction, so a single-cycle slip is caught at the end of the affected word.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_LATCH, SH_GAP} sh_state_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_WAIT, SQ_DELAY} sq_state_e;

  // Cycles taken by one word: launch cycle + data bits + load pulse + idle gap
  function automatic int unsigned word_cycles(int unsigned width, int unsigned half);
    return 1 + 2 * half * (width + 2);
  endfunction

endpackage

// File: rtl/prog_bit_timer.sv
module prog_bit_timer #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hi_phase,
  output logic bit_end
);
  localparam int unsigned BITP  = 2 * HALF;
  localparam int unsigned CNT_W = (BITP > 1) ? $clog2(BITP) : 1;

  logic [CNT_W-1:0] cnt;

  assign bit_end  = (cnt == CNT_W'(BITP - 1));
  assign hi_phase = (cnt >= CNT_W'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || bit_end)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0) || run) else $error("bit timer not cleared"); // R2
endmodule

// File: rtl/prog_word_shifter.sv
module prog_word_shifter
  import synth_prog_pkg::*;
#(
  parameter int unsigned W    = 23,
  parameter int unsigned HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] word,
  output logic         sclk,
  output logic         sdata,
  output logic         le,
  output logic         done
);
  localparam int unsigned BW = $clog2(W + 1);

  sh_state_e      st;
  logic [W-1:0]   shreg;
  logic [BW-1:0]  bitn;
  logic           hi_phase, bit_end;

  prog_bit_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st != SH_IDLE),
    .hi_phase(hi_phase), .bit_end(bit_end)
  );

  assign sclk  = (st == SH_SHIFT) && hi_phase;
  assign sdata = (st == SH_SHIFT) && shreg[W-1];
  assign le    = (st == SH_LATCH);
  assign done  = (st == SH_GAP) && bit_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SH_IDLE;
      shreg <= '0;
      bitn  <= '0;
    end else begin
      unique case (st)
        SH_IDLE: if (go) begin
          shreg <= word;
          bitn  <= '0;
          st    <= SH_SHIFT;
        end
        SH_SHIFT: if (bit_end) begin
          if (bitn == BW'(W - 1)) st <= SH_LATCH;
          else begin
            shreg <= shreg << 1;
            bitn  <= bitn + 1'b1;
          end
        end
        SH_LATCH: if (bit_end) st <= SH_GAP;
        SH_GAP:   if (bit_end) st <= SH_IDLE;
        default:  st <= SH_IDLE;
      endcase
    end
  end

  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata)) else $error("data moved while clock high"); // R2
  AST_LE_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> !sclk) else $error("clock toggled during load"); // R3
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SH_SHIFT) |-> (bitn < BW'(W))) else $error("bit index overran word"); // R2
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int unsigned W        = 23,
  parameter int unsigned NW       = 4,
  parameter int unsigned MAIN_IDX = 2,
  parameter int unsigned HALF     = 2,
  parameter int unsigned DLY_W    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            toggle_mode,
  input  logic [NW*W-1:0] prog_words,
  input  logic [W-1:0]    tog_base,
  input  logic [W-1:0]    tog_alt,
  input  logic [DLY_W-1:0] tog_delay,
  output logic            sclk,
  output logic            sdata,
  output logic            le,
  output logic            step,
  output logic            busy
);
  localparam int unsigned IW       = (NW > 1) ? $clog2(NW) : 1;
  localparam int unsigned WORD_CYC = word_cycles(W, HALF);
  localparam int unsigned WL_W     = $clog2(WORD_CYC + 1);

  sq_state_e        sq;
  logic [IW-1:0]    idx;
  logic             tog_q, alt_sel, main_q;
  logic [DLY_W-1:0] dcnt;
  logic [W-1:0]     cur_word;
  logic             go, wdone;
  logic [WL_W-1:0]  wlen;

  always_comb begin
    if (tog_q) cur_word = alt_sel ? tog_alt : tog_base;
    else       cur_word = prog_words[idx*W +: W];
  end

  assign go   = (sq == SQ_SEND);
  assign busy = (sq != SQ_IDLE);

  prog_word_shifter #(.W(W), .HALF(HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .word(cur_word),
    .sclk(sclk), .sdata(sdata), .le(le), .done(wdone)
  );

  assign step = le && main_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq      <= SQ_IDLE;
      idx     <= '0;
      tog_q   <= 1'b0;
      alt_sel <= 1'b0;
      main_q  <= 1'b0;
      dcnt    <= '0;
    end else begin
      unique case (sq)
        SQ_IDLE: if (start) begin
          idx     <= '0;
          tog_q   <= toggle_mode;
          alt_sel <= 1'b0;
          sq      <= SQ_SEND;
        end
        SQ_SEND: begin
          main_q <= tog_q || (idx == IW'(MAIN_IDX));
          sq     <= SQ_WAIT;
        end
        SQ_WAIT: if (wdone) begin
          if (tog_q) begin
            alt_sel <= ~alt_sel;
            if (!toggle_mode) sq <= SQ_IDLE;
            else begin
              dcnt <= tog_delay;
              sq   <= SQ_DELAY;
            end
          end else if (idx == IW'(NW - 1)) begin
            sq <= SQ_IDLE;
          end else begin
            idx <= idx + 1'b1;
            sq  <= SQ_SEND;
          end
        end
        SQ_DELAY: begin
          if (!toggle_mode)      sq <= SQ_IDLE;
          else if (dcnt == '0)   sq <= SQ_SEND;
          else                   dcnt <= dcnt - 1'b1;
        end
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  // Word-length monitor for the frame check below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wlen <= '0;
    else if (go)         wlen <= WL_W'(1);
    else if (wlen != '1) wlen <= wlen + 1'b1;
  end

  AST_STEP_NEEDS_LE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> le) else $error("trigger outside load pulse"); // R5
  AST_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (le || sclk) |-> busy) else $error("bus activity while idle"); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !wdone) |=> $stable(idx)) else $error("restart while busy"); // R8
  AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tog_q && le) |-> step) else $error("toggle event lost trigger"); // R6
  AST_WORD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wdone |-> (wlen == WL_W'(WORD_CYC - 1))) else $error("word frame length"); // R7
endmodule

// File: tb/synth_prog_seq_tb.sv
`timescale 1ns/1ps
module synth_prog_seq_tb;
  localparam int W = 23, NW = 4, HALF = 2, DLY_W = 12;
  localparam int BITP = 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, toggle_mode = 1'b0;
  logic [NW*W-1:0] prog_words = '0;
  logic [W-1:0] tog_base = '0, tog_alt = '0;
  logic [DLY_W-1:0] tog_delay = '0;
  logic sclk, sdata, le, step, busy;

  always #2 clk = ~clk;

  synth_prog_seq #(.W(W), .NW(NW), .MAIN_IDX(2), .HALF(HALF), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .toggle_mode(toggle_mode),
    .prog_words(prog_words), .tog_base(tog_base), .tog_alt(tog_alt),
    .tog_delay(tog_delay), .sclk(sclk), .sdata(sdata), .le(le),
    .step(step), .busy(busy)
  );

  int vectors = 0, fails = 0;

  function automatic int burst_gap();
    return BITP * (W + 2) + 1;
  endfunction
  function automatic int toggle_gap(int d);
    return BITP * (W + 2) + d + 2;
  endfunction

  // Port monitor, sampled on the falling clock edge
  logic [W-1:0] cap;
  logic [W-1:0] words_q [0:63];
  int bits_q [0:63], rise_q [0:63];
  logic step_q [0:63];
  int nw = 0, nbits = 0, le_len = 0, le_len_err = 0, step_err = 0, busy_cnt = 0, cyc = 0;
  logic prev_sclk = 1'b0, prev_le = 1'b0, step_at_rise = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (sclk && !prev_sclk) begin cap = {cap[W-2:0], sdata}; nbits++; end
    if (le && !prev_le) begin
      if (nw < 64) begin
        words_q[nw] = cap; bits_q[nw] = nbits; step_q[nw] = step; rise_q[nw] = cyc;
      end
      nw++; nbits = 0; le_len = 0; step_at_rise = step;
    end
    if (le) begin
      le_len++;
      if (step != step_at_rise) step_err++;
    end
    if (!le && prev_le && le_len != BITP) le_len_err++;
    if (step && !le) step_err++;
    prev_sclk = sclk; prev_le = le;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic clear_mon();
    nw = 0; nbits = 0; le_len_err = 0; step_err = 0; busy_cnt = 0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      if (!busy) break;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 40000; i++) begin
      @(posedge clk); #1;
      if (nw >= n) break;
    end
  endtask

  task automatic run_burst(input logic [NW*W-1:0] words, input bit extra_start);
    clear_mon();
    prog_words = words; toggle_mode = 1'b0;
    pulse_start();
    if (extra_start) begin
      repeat (150) @(posedge clk);
      #1 start = 1'b1; toggle_mode = 1'b1;
      @(posedge clk); #1 start = 1'b0; toggle_mode = 1'b0;
    end
    wait_idle();
    check(nw == NW, extra_start ? "R8 word count" : "R4 word count", nw, NW);
    check(busy_cnt == NW * burst_gap(), extra_start ? "R8 busy length" : "R4 busy length", busy_cnt, NW * burst_gap());
    for (int k = 0; k < NW; k++) begin
      check(words_q[k] == words[k*W +: W], "R4 word order", words_q[k], words[k*W +: W]);
      check(bits_q[k] == W, "R2 bit count", bits_q[k], W);
      check(step_q[k] == (k == 2), "R5 trigger word", step_q[k], (k == 2));
      if (k > 0)
        check(rise_q[k] - rise_q[k-1] == burst_gap(), "R7 burst spacing", rise_q[k] - rise_q[k-1], burst_gap());
    end
    check(le_len_err == 0, "R3 load width", le_len_err, 0);
    check(step_err == 0, "R5 trigger shape", step_err, 0);
  endtask

  task automatic run_toggle(input logic [W-1:0] b, input logic [W-1:0] a, input int d,
                            input int nev, input bit stop_in_delay);
    clear_mon();
    tog_base = b; tog_alt = a; tog_delay = DLY_W'(d); toggle_mode = 1'b1;
    pulse_start();
    wait_words(nev);
    if (stop_in_delay) begin
      repeat (2 * BITP + 4) @(posedge clk);
      #1 toggle_mode = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      check(busy == 1'b0, "R9 stop in delay", busy, 0);
    end else begin
      toggle_mode = 1'b0;
    end
    wait_idle();
    check(nw == nev, "R9 toggle stop count", nw, nev);
    for (int k = 0; k < nev; k++) begin
      check(words_q[k] == ((k % 2) ? a : b), "R6 alternation", words_q[k], (k % 2) ? a : b);
      check(bits_q[k] == W, "R2 bit count", bits_q[k], W);
      check(step_q[k] == 1'b1, "R6 trigger each event", step_q[k], 1);
      if (k > 0)
        check(rise_q[k] - rise_q[k-1] == toggle_gap(d), "R7 toggle spacing", rise_q[k] - rise_q[k-1], toggle_gap(d));
    end
    check(le_len_err == 0, "R3 load width", le_len_err, 0);
    check(step_err == 0, "R5 trigger shape", step_err, 0);
  endtask

  function automatic logic [NW*W-1:0] rand_words();
    logic [NW*W-1:0] v;
    for (int k = 0; k < NW; k++) v[k*W +: W] = W'($urandom);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_0291));
    repeat (4) @(posedge clk);
    #1;
    check({sclk, sdata, le, step, busy} == 5'b0, "R1 reset outputs", {sclk, sdata, le, step, busy}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check({sclk, sdata, le, step, busy} == 5'b0, "R1 idle outputs", {sclk, sdata, le, step, busy}, 0);

    run_burst({W'(23'h7FFFFF), W'(23'h000001), W'(23'h400000), W'(23'h555555)}, 1'b0);
    run_burst('0, 1'b0);
    for (int i = 0; i < 5; i++) run_burst(rand_words(), 1'b0);
    run_burst(rand_words(), 1'b1);   // R8 second strobe while busy

    run_toggle(23'h2AAAAA, 23'h155555, 0, 5, 1'b0);
    run_toggle(W'($urandom), W'($urandom), 37, 4, 1'b0);
    run_toggle(W'($urandom), W'($urandom), 200, 3, 1'b1);
    run_toggle(W'($urandom), W'($urandom), int'($urandom_range(1, 60)), 1, 1'b0);

    run_burst(rand_words(), 1'b0);
    report();
  end
endmodule